// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame is kept, judging only its destination address. A receive datapath presents the destination address together with a single-cycle `start` strobe. The block then walks the address one byte per clock and builds the Ethernet CRC-32 hash of the address as it goes. After the last byte it returns an accept verdict plus broadcast and multicast indications, which the datapath can copy into its receive status word.

The decision follows a fixed priority. Promiscuous mode comes first, then broadcast, then pass-all-multicast. After those, the frame is matched either exactly against the station address or through a 64-bit hash table. The choice between exact and hash matching is made separately for group (multicast) frames and for individual (unicast) frames. Exact matching can be inverted. The station address, the hash table and the mode bits are plain inputs. The surrounding register file owns them and must hold them steady until the verdict appears.

Top module: `eth_da_filter`

## Requirements
- R1: `done` is a one-cycle pulse raised exactly ADDR_BYTES (default 6) clock edges after the edge that samples `start` high. A new `start` while a frame is in progress abandons that frame and restarts on the new address, so only one `done` follows, timed from the last `start`.
- R2: When `promisc` is 1 at the decision, the frame is accepted whatever the address and the other mode bits are.
- R3: An all-ones destination is a broadcast. When `promisc` is 0, a broadcast is accepted if `bcast_block` is 0 and rejected if `bcast_block` is 1.
- R4: A frame whose first byte has bit 0 set is a group frame. The first byte is `dest_addr[47:40]`, so this bit is `dest_addr[40]`. A non-broadcast group frame is accepted at once when `mcast_all` is 1 and `promisc` is 0.
- R5: For the remaining frames, a group frame uses hash matching when `mcast_hash` is 1 and exact matching otherwise. An individual frame uses hash matching when `ucast_hash` is 1 and exact matching otherwise.
- R6: Exact matching compares all 48 bits with `station_addr`. The frame is accepted on equality, or on inequality when `invert_exact` is 1.
- R7: The hash index is bits 31:26 of a CRC register. The register starts at all ones and uses polynomial 0x04C11DB7, shifted MSB-first. It takes the address bytes first byte (`dest_addr[47:40]`) first, each byte bit 0 first, and the result is not complemented. Index bit 5 picks `hash_hi` (1) or `hash_lo` (0), and bits 4:0 pick the bit within that word. The frame is accepted when that bit is 1.
- R8: With `done`, `is_bcast` is 1 only for the all-ones address. `is_mcast` is 1 for a group address that is not broadcast.
- R9: After reset, `done`, `accept`, `is_bcast` and `is_mcast` are 0. The verdict outputs keep their value from one `done` to the next, even if the mode inputs change in between.
- R10: `invert_exact` has no effect on a frame decided by hash matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin evaluation of `dest_addr` |
| dest_addr | input | 48 | Destination address, first byte in bits 47:40 |
| station_addr | input | 48 | Own station address for exact matching |
| hash_hi | input | 32 | Hash table bits for index 32..63 |
| hash_lo | input | 32 | Hash table bits for index 0..31 |
| promisc | input | 1 | Accept every frame |
| bcast_block | input | 1 | Reject broadcast frames |
| mcast_all | input | 1 | Accept every group frame |
| mcast_hash | input | 1 | Group frames use hash matching |
| ucast_hash | input | 1 | Individual frames use hash matching |
| invert_exact | input | 1 | Exact matching accepts on mismatch |
| done | output | 1 | Verdict valid pulse |
| accept | output | 1 | Frame accepted |
| is_bcast | output | 1 | Address was broadcast |
| is_mcast | output | 1 | Address was group, not broadcast |

## Verification
A fault in the byte counter shows up as `done` arriving early, late or twice, and the latency is checked on every frame. A fault in the CRC register shows up only in the hash path, and only at the `done` of that frame. The bench therefore builds one-hot and one-cold hash tables around the index it computes itself, so that a single wrong index bit flips the verdict. A wrong latched address shows up at once in the broadcast and multicast flags and in the exact-match verdict.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;

   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

   typedef struct packed {
      logic promisc;
      logic bcast_block;
      logic mcast_all;
      logic mcast_hash;
      logic ucast_hash;
      logic invert_exact;
   } filt_mode_t;

   typedef struct packed {
      logic bcast;
      logic group;
      logic mcast;
      logic exact_hit;
   } addr_class_t;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_t;

endpackage

// File: rtl/da_crc_engine.sv
module da_crc_engine
   import da_filter_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W      = 6,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr_q,
   output logic              last_step,
   output logic [IDX_W-1:0]  idx_next
);

   eng_state_t        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [31:0]       crc_q;
   logic [ADDR_W-1:0] sh_q;
   logic [7:0]        cur_byte;
   logic [31:0]       stage [0:8];

   assign cur_byte = sh_q[ADDR_W-1 -: 8];
   assign stage[0] = crc_q;

   // one serial CRC step per data bit, bit 0 of the byte first
   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb         = stage[b][31] ^ cur_byte[b];
      assign stage[b+1] = {stage[b][30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
   end

   assign idx_next  = stage[8][31 -: IDX_W];
   assign last_step = (st_q == ENG_RUN) && (cnt_q == CNT_W'(ADDR_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         cnt_q  <= '0;
         crc_q  <= '1;
         sh_q   <= '0;
         addr_q <= '0;
      end else if (start) begin
         st_q   <= ENG_RUN;
         cnt_q  <= '0;
         crc_q  <= '1;
         sh_q   <= addr;
         addr_q <= addr;
      end else if (st_q == ENG_RUN) begin
         crc_q <= stage[8];
         sh_q  <= sh_q << 8;
         cnt_q <= cnt_q + 1'b1;
         if (last_step) st_q <= ENG_IDLE;
      end
   end

endmodule

// File: rtl/da_classify.sv
module da_classify
   import da_filter_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   localparam int ADDR_W    = 8 * ADDR_BYTES
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] station,
   output addr_class_t       cls
);

   always_comb begin
      cls.bcast     = &addr;
      cls.group     = addr[ADDR_W-8];
      cls.mcast     = addr[ADDR_W-8] && !(&addr);
      cls.exact_hit = (addr == station);
   end

endmodule

// File: rtl/da_decide.sv
module da_decide
   import da_filter_pkg::*;
#(
   parameter int HASH_WORD_W = 32,
   localparam int IDX_W      = $clog2(2 * HASH_WORD_W),
   localparam int BIT_W      = IDX_W - 1
) (
   input  filt_mode_t             mode,
   input  addr_class_t            cls,
   input  logic [IDX_W-1:0]       idx,
   input  logic [HASH_WORD_W-1:0] hash_hi,
   input  logic [HASH_WORD_W-1:0] hash_lo,
   output logic                   accept
);

   logic             use_hash;
   logic             hash_bit;
   logic [BIT_W-1:0] bit_sel;

   assign bit_sel  = idx[BIT_W-1:0];
   assign use_hash = cls.group ? mode.mcast_hash : mode.ucast_hash;
   assign hash_bit = idx[IDX_W-1] ? hash_hi[bit_sel] : hash_lo[bit_sel];

   always_comb begin
      if (mode.promisc)
         accept = 1'b1;
      else if (cls.bcast)
         accept = !mode.bcast_block;
      else if (cls.group && mode.mcast_all)
         accept = 1'b1;
      else if (use_hash)
         accept = hash_bit;
      else
         accept = cls.exact_hit ^ mode.invert_exact;
   end

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
   import da_filter_pkg::*;
#(
   parameter int ADDR_BYTES  = 6,
   parameter int HASH_WORD_W = 32,
   localparam int ADDR_W     = 8 * ADDR_BYTES,
   localparam int IDX_W      = $clog2(2 * HASH_WORD_W)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [ADDR_W-1:0]      dest_addr,
   input  logic [ADDR_W-1:0]      station_addr,
   input  logic [HASH_WORD_W-1:0] hash_hi,
   input  logic [HASH_WORD_W-1:0] hash_lo,
   input  logic                   promisc,
   input  logic                   bcast_block,
   input  logic                   mcast_all,
   input  logic                   mcast_hash,
   input  logic                   ucast_hash,
   input  logic                   invert_exact,
   output logic                   done,
   output logic                   accept,
   output logic                   is_bcast,
   output logic                   is_mcast
);

   if (ADDR_BYTES < 1) begin : g_bad_bytes
      $error("ADDR_BYTES must be at least 1");
   end
   if (HASH_WORD_W < 2 || (HASH_WORD_W & (HASH_WORD_W - 1)) != 0) begin : g_bad_hash
      $error("HASH_WORD_W must be a power of two of at least 2");
   end
   if (IDX_W > 32) begin : g_bad_idx
      $error("hash index wider than the CRC");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              last_step;
   logic [IDX_W-1:0]  idx_next;
   addr_class_t       cls;
   filt_mode_t        mode;
   logic              verdict;

   assign mode = '{promisc:      promisc,
                   bcast_block:  bcast_block,
                   mcast_all:    mcast_all,
                   mcast_hash:   mcast_hash,
                   ucast_hash:   ucast_hash,
                   invert_exact: invert_exact};

   da_crc_engine #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .addr      (dest_addr),
      .addr_q    (addr_q),
      .last_step (last_step),
      .idx_next  (idx_next)
   );

   da_classify #(.ADDR_BYTES(ADDR_BYTES)) u_cls (
      .addr    (addr_q),
      .station (station_addr),
      .cls     (cls)
   );

   da_decide #(.HASH_WORD_W(HASH_WORD_W)) u_dec (
      .mode    (mode),
      .cls     (cls),
      .idx     (idx_next),
      .hash_hi (hash_hi),
      .hash_lo (hash_lo),
      .accept  (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         accept   <= 1'b0;
         is_bcast <= 1'b0;
         is_mcast <= 1'b0;
      end else begin
         done <= last_step && !start;
         if (last_step && !start) begin
            accept   <= verdict;
            is_bcast <= cls.bcast;
            is_mcast <= cls.mcast;
         end
      end
   end

endmodule

// File: rtl/eth_da_filter_chk.sv
module eth_da_filter_chk #(
   parameter int ADDR_BYTES = 6,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int CNT_W     = $clog2(ADDR_BYTES + 2) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] dest_addr,
   input logic              promisc,
   input logic              bcast_block,
   input logic              done,
   input logic              accept,
   input logic              is_bcast,
   input logic              is_mcast
);

   logic              run_q;
   logic [CNT_W-1:0]  lat_q;
   logic [ADDR_W-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         lat_q <= '0;
         cap_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         lat_q <= '0;
         cap_q <= dest_addr;
      end else if (run_q) begin
         lat_q <= lat_q + 1'b1;
         if (done) run_q <= 1'b0;
      end
   end

   // R1: verdict arrives exactly ADDR_BYTES edges after the last start
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_q && lat_q == CNT_W'(ADDR_BYTES)));

   // R1: done is a single-cycle pulse
   p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: promiscuous accepts everything
   p_promisc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(promisc)) |-> accept);

   // R3: broadcast blocked when not promiscuous
   p_bcast_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_bcast && !$past(promisc) && $past(bcast_block)) |-> !accept);

   // R3: broadcast passes when not blocked
   p_bcast_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_bcast && !$past(bcast_block)) |-> accept);

   // R8: broadcast flag follows the captured address
   p_bcast_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (is_bcast == (&cap_q)));

   // R8: multicast flag excludes broadcast
   p_mcast_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (is_mcast == (cap_q[ADDR_W-8] && !(&cap_q))));

   // R9: verdict held between completions
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(accept) && $stable(is_bcast) && $stable(is_mcast)));

endmodule

bind eth_da_filter eth_da_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .dest_addr   (dest_addr),
   .promisc     (promisc),
   .bcast_block (bcast_block),
   .done        (done),
   .accept      (accept),
   .is_bcast    (is_bcast),
   .is_mcast    (is_mcast)
);

// File: tb/tb_eth_da_filter.sv
`timescale 1ns/1ps
module tb_eth_da_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [47:0] dest_addr = '0;
   logic [47:0] station_addr = 48'h02_11_22_33_44_56;
   logic [31:0] hash_hi = '0;
   logic [31:0] hash_lo = '0;
   logic        promisc = 1'b0;
   logic        bcast_block = 1'b0;
   logic        mcast_all = 1'b0;
   logic        mcast_hash = 1'b0;
   logic        ucast_hash = 1'b0;
   logic        invert_exact = 1'b0;
   logic        done, accept, is_bcast, is_mcast;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   int last_lat = 0;
   logic got_acc, got_bc, got_mc;

   always #10 clk = ~clk;   // 50 MHz

   eth_da_filter dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dest_addr(dest_addr),
      .station_addr(station_addr), .hash_hi(hash_hi), .hash_lo(hash_lo),
      .promisc(promisc), .bcast_block(bcast_block), .mcast_all(mcast_all),
      .mcast_hash(mcast_hash), .ucast_hash(ucast_hash),
      .invert_exact(invert_exact), .done(done), .accept(accept),
      .is_bcast(is_bcast), .is_mcast(is_mcast)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] by = a[47 - 8*i -: 8];
         for (int j = 0; j < 8; j++) begin
            logic fb = c[31] ^ by[j];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
         end
      end
      return c[31:26];
   endfunction

   function automatic logic model(input logic [47:0] a);
      logic [5:0] ix = hidx(a);
      logic hb = ix[5] ? hash_hi[ix[4:0]] : hash_lo[ix[4:0]];
      if (promisc) return 1'b1;
      if (&a) return !bcast_block;
      if (a[40] && mcast_all) return 1'b1;
      if (a[40] ? mcast_hash : ucast_hash) return hb;
      return (a == station_addr) ^ invert_exact;
   endfunction

   task automatic set_mode(input logic p, bb, ma, mh, uh, inv);
      promisc = p; bcast_block = bb; mcast_all = ma;
      mcast_hash = mh; ucast_hash = uh; invert_exact = inv;
   endtask

   task automatic run_frame(input logic [47:0] a);
      @(negedge clk);
      dest_addr = a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      last_lat = 0;
      for (int k = 0; k < 40; k++) begin
         if (done) break;
         @(negedge clk);
         last_lat++;
      end
      got_acc = accept; got_bc = is_bcast; got_mc = is_mcast;
   endtask

   task automatic t_reset;
      chk(done == 1'b0 && accept == 1'b0 && is_bcast == 1'b0 && is_mcast == 1'b0,
          "R9 reset outputs", {done, accept, is_bcast, is_mcast}, 0);
   endtask

   task automatic t_latency;
      set_mode(0, 0, 0, 0, 0, 0);
      run_frame(station_addr);
      chk(last_lat == 6, "R1 latency", last_lat, 6);
      @(negedge clk);
      chk(done == 1'b0, "R1 single pulse", done, 0);
   endtask

   task automatic t_promisc;
      set_mode(1, 1, 0, 1, 1, 1);
      run_frame(48'h1234_5678_9ABC);
      chk(got_acc == 1'b1, "R2 promisc unicast", got_acc, 1);
      run_frame(48'hFFFF_FFFF_FFFF);
      chk(got_acc == 1'b1, "R2 promisc over broadcast block", got_acc, 1);
   endtask

   task automatic t_bcast;
      set_mode(0, 0, 0, 0, 0, 0);
      run_frame(48'hFFFF_FFFF_FFFF);
      chk(got_acc == 1'b1, "R3 broadcast allowed", got_acc, 1);
      chk(got_bc == 1'b1 && got_mc == 1'b0, "R8 broadcast flags", {got_bc, got_mc}, 2'b10);
      bcast_block = 1'b1;
      run_frame(48'hFFFF_FFFF_FFFF);
      chk(got_acc == 1'b0, "R3 broadcast blocked", got_acc, 0);
   endtask

   task automatic t_mcast_pass;
      set_mode(0, 0, 1, 0, 0, 0);
      run_frame(48'h0100_5E00_0001);
      chk(got_acc == 1'b1, "R4 pass all multicast", got_acc, 1);
      chk(got_bc == 1'b0 && got_mc == 1'b1, "R8 multicast flags", {got_bc, got_mc}, 2'b01);
      mcast_all = 1'b0;
      run_frame(48'h0100_5E00_0001);
      chk(got_acc == 1'b0, "R4 multicast without pass-all, exact miss", got_acc, 0);
      run_frame(48'h0200_0000_0001);
      chk(got_mc == 1'b0 && got_bc == 1'b0, "R8 unicast flags", {got_bc, got_mc}, 0);
   endtask

   task automatic t_exact;
      set_mode(0, 0, 0, 0, 0, 0);
      run_frame(station_addr);
      chk(got_acc == 1'b1, "R6 exact hit", got_acc, 1);
      run_frame(station_addr ^ 48'h1);
      chk(got_acc == 1'b0, "R6 exact miss last bit", got_acc, 0);
      invert_exact = 1'b1;
      run_frame(station_addr);
      chk(got_acc == 1'b0, "R6 inverted hit", got_acc, 0);
      run_frame(station_addr ^ 48'h8000_0000_0000);
      chk(got_acc == 1'b1, "R6 inverted miss", got_acc, 1);
   endtask

   task automatic t_hash(input bit grp);
      logic [47:0] a;
      logic [5:0] ix;
      for (int i = 0; i < 10; i++) begin
         a = {8'h02 | {7'd0, grp}, 8'(i * 37), 8'(i * 91 + 3), 8'(i), 8'hA5 ^ 8'(i), 8'(255 - i*13)};
         ix = hidx(a);
         set_mode(0, 0, 0, grp, !grp, i[0]);
         hash_hi = ix[5] ? (32'h1 << ix[4:0]) : 32'h0;
         hash_lo = ix[5] ? 32'h0 : (32'h1 << ix[4:0]);
         run_frame(a);
         chk(got_acc == 1'b1, grp ? "R7 R5 group hash bit set" : "R7 R5 unicast hash bit set", got_acc, 1);
         if (i[0]) chk(got_acc == 1'b1, "R10 invert ignored on hash", got_acc, 1);
         hash_hi = ~hash_hi; hash_lo = ~hash_lo;
         run_frame(a);
         chk(got_acc == 1'b0, "R7 hash bit clear", got_acc, 0);
      end
      hash_hi = '0; hash_lo = '0;
   endtask

   task automatic t_select;
      // group hashing selected, but a unicast frame still uses exact match
      set_mode(0, 0, 0, 1, 0, 0);
      hash_hi = '0; hash_lo = '0;
      run_frame(station_addr);
      chk(got_acc == 1'b1, "R5 unicast exact while group hashes", got_acc, 1);
      // unicast hashing selected, group frame exact-matched against station
      set_mode(0, 0, 0, 0, 1, 0);
      hash_hi = '1; hash_lo = '1;
      run_frame(48'h0300_0000_0007);
      chk(got_acc == 1'b0, "R5 group exact while unicast hashes", got_acc, 0);
      hash_hi = '0; hash_lo = '0;
   endtask

   task automatic t_restart;
      int seen = 0;
      set_mode(0, 0, 0, 0, 0, 0);
      @(negedge clk); dest_addr = 48'h0A00_0000_0001; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      @(negedge clk); dest_addr = station_addr; start = 1'b1;
      @(negedge clk); start = 1'b0;
      last_lat = 0;
      for (int k = 0; k < 40; k++) begin
         if (done) break;
         @(negedge clk);
         last_lat++;
      end
      got_acc = accept;
      chk(last_lat == 6, "R1 restart latency", last_lat, 6);
      chk(got_acc == 1'b1, "R1 restart uses new address", got_acc, 1);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (done) seen++;
      end
      chk(seen == 0, "R1 no stale done", seen, 0);
   endtask

   task automatic t_hold;
      set_mode(0, 0, 0, 0, 0, 0);
      run_frame(48'h0200_0000_0099);
      chk(got_acc == 1'b0, "R9 base verdict", got_acc, 0);
      promisc = 1'b1;
      repeat (4) @(negedge clk);
      chk(accept == 1'b0, "R9 verdict held after mode change", accept, 0);
      promisc = 1'b0;
   endtask

   task automatic t_mix;
      logic [47:0] a;
      logic e;
      for (int i = 0; i < 12; i++) begin
         a = {8'(i * 29 + 1), 40'h13_57_9B_DF_02 ^ 40'(i * 7919)};
         set_mode(i[3], i[0], i[1], i[2], !i[2], i[1]);
         hash_hi = 32'hA5A5_0F0F ^ 32'(i); hash_lo = 32'h3C3C_F00F + 32'(i);
         e = model(a);
         run_frame(a);
         chk(got_acc == e, "R2 R3 R4 R5 R6 R7 mixed", got_acc, e);
      end
      hash_hi = '0; hash_lo = '0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_latency;
      t_promisc;
      t_bcast;
      t_mcast_pass;
      t_exact;
      t_hash(1'b0);
      t_hash(1'b1);
      t_select;
      t_restart;
      t_hold;
      t_mix;
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule